// File: doc/BRIEF.md
# Dual-CPU Mailbox Flag Controller

This block lets two processors pass notifications to each other over a fixed set of channels. Each processor owns one flag per channel. A processor raises its own flag when a message is ready. The peer lowers that flag once it has consumed the message. Each processor has its own bank of registers: an interrupt-enable register, a per-channel mask register, a write-only strobe register for raising and lowering flags, and a read-only view of the flags it owns.

Each processor receives two interrupt lines. The receive-occupied line reports that the peer holds a flag on an unmasked channel. The transmit-free line reports that the processor's own flag has been released on an unmasked channel. Access goes through one synchronous register port. A CPU-select bit picks the bank, a 2-bit offset picks the register, and read data comes back one cycle after the read strobe.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, every flag is 0, every mask bit is 1, both interrupt enables are 0, all four interrupt lines are 0 and rdData is 0.
- R2: Offset 0 is the enable register of the selected CPU. Bit 0 is the receive-occupied enable and bit 1 is the transmit-free enable. Both bits read back as written and all other bits read 0.
- R3: Offset 1 is the mask register. Bits [NUM_CH-1:0] mask receive-occupied per channel and bits [16+NUM_CH-1:16] mask transmit-free per channel. A 1 masks the channel. The register reads back as written, with all other bits 0.
- R4: Writing offset 2 with a 1 in bit 16+ch raises the selected CPU's own flag for channel ch. Bits written as 0 change nothing.
- R5: Writing offset 2 with a 1 in bit ch lowers the peer CPU's flag for channel ch. Bits written as 0 change nothing, and the writer's own flags are untouched.
- R6: A read of offset 2 returns 0.
- R7: Offset 3 returns the selected CPU's own flags in bits [NUM_CH-1:0]. All other bits are 0.
- R8: rdData takes the addressed value on the clock edge that samples rdEn and holds its value while rdEn is low.
- R9: irqRxOcc[c] is 1 exactly when CPU c's receive-occupied enable is 1 and some channel has the peer's flag set with CPU c's receive-occupied mask bit at 0.
- R10: irqTxFree[c] is 1 exactly when CPU c's transmit-free enable is 1 and some channel has CPU c's own flag clear with its transmit-free mask bit at 0.
- R11: A write to the enable or mask register of one CPU leaves the other CPU's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| cpuSel | input | 1 | Register bank select (CPU 0 or CPU 1) |
| addr | input | 2 | Register offset |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| irqRxOcc | output | 2 | Receive-occupied interrupt, one bit per CPU |
| irqTxFree | output | 2 | Transmit-free interrupt, one bit per CPU |

## Verification
The bench targets the cross-CPU direction of the strobe register. If a design lowered the writer's own flag on a clear strobe, the writer would see transmit-free while the peer still saw receive-occupied, and the status reads would show that divergence. It also sends writes that carry set and clear bits together, and writes of all zeros. A design that treated zero bits as clears would drop pending flags, and this shows up at once on the interrupt lines. Masks are swept channel by channel with the enables toggled, which exposes inverted mask polarity, OR terms taken from the wrong CPU's flags, and bank writes that leak into the other CPU.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Bit position where the upper per-channel field starts (tx mask, set strobes)
  localparam int HI_OFS = 16;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STAT   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    cpu;
    logic    wrCtrl;
    logic    wrMask;
    logic    wrSetClr;
    logic    rdStb;
    regSel_e rdSel;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       cpuSel,
  input  logic [1:0] addr,
  output mbxStrobe_t stb
);
  regSel_e sel;
  assign sel = regSel_e'(addr);

  always_comb begin
    stb          = '0;
    stb.cpu      = cpuSel;
    stb.wrCtrl   = wrEn && (sel == REG_CTRL);
    stb.wrMask   = wrEn && (sel == REG_MASK);
    stb.wrSetClr = wrEn && (sel == REG_SETCLR);
    stb.rdStb    = rdEn;
    stb.rdSel    = sel;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        irqRxOcc,
  output logic [1:0]        irqTxFree
);
  localparam int NUM_CPU = 2;

  logic [NUM_CH-1:0] flags  [NUM_CPU];
  logic [NUM_CH-1:0] rxMask [NUM_CPU];
  logic [NUM_CH-1:0] txMask [NUM_CPU];
  logic              rxIe   [NUM_CPU];
  logic              txIe   [NUM_CPU];

  logic [NUM_CH-1:0] setField, clrField;
  assign setField = wrData[HI_OFS +: NUM_CH];
  assign clrField = wrData[0 +: NUM_CH];

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  for (genvar g = 0; g < NUM_CPU; g++) begin : gCpu
    logic              selfSel;
    logic [NUM_CH-1:0] flagQ, rxMaskQ, txMaskQ, setBits, clrBits;
    logic              rxIeQ, txIeQ;

    assign selfSel = (stb.cpu == 1'(g));
    // own set strobe raises this CPU's flag; the peer's clear strobe drops it
    assign setBits = (stb.wrSetClr && selfSel)  ? setField : '0;
    assign clrBits = (stb.wrSetClr && !selfSel) ? clrField : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ   <= '0;
        rxMaskQ <= '1;
        txMaskQ <= '1;
        rxIeQ   <= 1'b0;
        txIeQ   <= 1'b0;
      end else begin
        flagQ <= (flagQ | setBits) & ~clrBits;
        if (stb.wrCtrl && selfSel) begin
          rxIeQ <= wrData[0];
          txIeQ <= wrData[1];
        end
        if (stb.wrMask && selfSel) begin
          rxMaskQ <= clrField;
          txMaskQ <= setField;
        end
      end
    end

    assign flags[g]  = flagQ;
    assign rxMask[g] = rxMaskQ;
    assign txMask[g] = txMaskQ;
    assign rxIe[g]   = rxIeQ;
    assign txIe[g]   = txIeQ;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : gIrq
    assign irqRxOcc[g]  = rxIe[g] && |(flags[1-g] & ~rxMask[g]);
    assign irqTxFree[g] = txIe[g] && |(~flags[g] & ~txMask[g]);
  end

  logic [DATA_W-1:0] readNext;
  always_comb begin
    readNext = '0;
    unique case (stb.rdSel)
      REG_CTRL: begin
        readNext[0] = rxIe[stb.cpu];
        readNext[1] = txIe[stb.cpu];
      end
      REG_MASK: begin
        readNext[0 +: NUM_CH]      = rxMask[stb.cpu];
        readNext[HI_OFS +: NUM_CH] = txMask[stb.cpu];
      end
      REG_STAT:   readNext[0 +: NUM_CH] = flags[stb.cpu];
      REG_SETCLR: readNext = '0;
      default:    readNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= readNext;
  end
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              cpuSel,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        irqRxOcc,
  output logic [1:0]        irqTxFree
);
  mbxStrobe_t stb;

  mbx_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .cpuSel (cpuSel),
    .addr   (addr),
    .stb    (stb)
  );

  mbx_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .rdData    (rdData),
    .irqRxOcc  (irqRxOcc),
    .irqTxFree (irqTxFree)
  );
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        irqRxOcc,
  input logic [1:0]        irqTxFree
);
  // R8: read data only moves on a read
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R6: strobe register reads as zero
  assert_setclr_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2) |=> (rdData == '0));

  // R7: status has nothing above the channel field
  assert_stat_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd3) |=> (rdData[DATA_W-1:NUM_CH] == '0));

  // R9: receive interrupts only change after a register write
  assert_rx_irq_needs_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqRxOcc) |-> $past(wrEn));

  // R10: transmit interrupts only change after a register write
  assert_tx_irq_needs_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqTxFree) |-> $past(wrEn));
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mbx_flag_ctrl.sv
module sim_mbx_flag_ctrl;
  localparam int NCH = 6;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0, cpuSel = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [1:0]    irqRxOcc, irqTxFree;

  always #2 clk = ~clk;

  mbx_flag_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .cpuSel(cpuSel),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqRxOcc(irqRxOcc), .irqTxFree(irqTxFree)
  );

  // behavioural reference state
  bit          mFlag [2][NCH];
  bit          mRxM  [2][NCH];
  bit          mTxM  [2][NCH];
  bit          mRxIe [2];
  bit          mTxIe [2];
  logic [31:0] mRd;
  int compared = 0, mismatched = 0;

  function automatic void modelReset();
    for (int c = 0; c < 2; c++) begin
      mRxIe[c] = 0; mTxIe[c] = 0;
      for (int k = 0; k < NCH; k++) begin
        mFlag[c][k] = 0; mRxM[c][k] = 1; mTxM[c][k] = 1;
      end
    end
    mRd = 0;
  endfunction

  function automatic logic [31:0] modelRead(int c, int a);
    logic [31:0] v = 0;
    if (a == 0) begin v[0] = mRxIe[c]; v[1] = mTxIe[c]; end
    else if (a == 1)
      for (int k = 0; k < NCH; k++) begin v[k] = mRxM[c][k]; v[16+k] = mTxM[c][k]; end
    else if (a == 3)
      for (int k = 0; k < NCH; k++) v[k] = mFlag[c][k];
    return v;
  endfunction

  function automatic void modelWrite(int c, int a, logic [31:0] d);
    if (a == 0) begin mRxIe[c] = d[0]; mTxIe[c] = d[1]; end
    else if (a == 1)
      for (int k = 0; k < NCH; k++) begin mRxM[c][k] = d[k]; mTxM[c][k] = d[16+k]; end
    else if (a == 2)
      for (int k = 0; k < NCH; k++) begin
        if (d[16+k]) mFlag[c][k] = 1;
        if (d[k])    mFlag[1-c][k] = 0;
      end
  endfunction

  function automatic void compareAll(string req);
    logic [1:0] eRx = 0, eTx = 0;
    for (int c = 0; c < 2; c++) begin
      bit anyRx = 0, anyTx = 0;
      for (int k = 0; k < NCH; k++) begin
        if (mFlag[1-c][k] && !mRxM[c][k]) anyRx = 1;
        if (!mFlag[c][k] && !mTxM[c][k])  anyTx = 1;
      end
      eRx[c] = mRxIe[c] && anyRx;
      eTx[c] = mTxIe[c] && anyTx;
    end
    compared++;
    if (rdData !== mRd) begin
      mismatched++;
      $display("FAIL %s rdData actual=%h expected=%h", req, rdData, mRd);
    end
    compared++;
    if (irqRxOcc !== eRx) begin
      mismatched++;
      $display("FAIL %s irqRxOcc actual=%b expected=%b", req, irqRxOcc, eRx);
    end
    compared++;
    if (irqTxFree !== eTx) begin
      mismatched++;
      $display("FAIL %s irqTxFree actual=%b expected=%b", req, irqTxFree, eTx);
    end
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(bit w, bit r, int c, int a, logic [31:0] d, string req);
    wrEn = w; rdEn = r; cpuSel = c[0]; addr = a[1:0]; wrData = d;
    @(posedge clk);
    #1;
    if (r) mRd = modelRead(c, a);
    if (w) modelWrite(c, a, d);
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    compareAll(req);
  endtask

  task automatic wr(int c, int a, logic [31:0] d, string req);
    step(1, 0, c, a, d, req);
  endtask

  task automatic rd(int c, int a, string req);
    step(0, 1, c, a, 0, req);
  endtask

  task automatic idle(string req);
    step(0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    idle("R1");
    rd(0, 0, "R1"); rd(0, 1, "R1"); rd(1, 1, "R1"); rd(1, 3, "R1");
    // R2 enables, R11 bank isolation
    wr(0, 0, 32'h0000_0003, "R2");
    rd(0, 0, "R2");
    rd(1, 0, "R11");
    wr(0, 0, 32'hFFFF_FFFE, "R2");
    rd(0, 0, "R2");
    wr(0, 0, 32'h0000_0003, "R2");
    // R3 mask readback; unmasked tx channel 2 -> R10 transmit-free
    wr(0, 1, 32'h003B_003F, "R10");
    rd(0, 1, "R3");
    rd(1, 1, "R11");
    // R4 own set; status R7
    wr(0, 2, 32'h0004_0000, "R4");
    rd(0, 3, "R7");
    rd(1, 3, "R7");
    // R9 receive-occupied at CPU1
    wr(1, 0, 32'h0000_0001, "R9");
    wr(1, 1, 32'h003F_003B, "R9");
    // zero write changes nothing (R4/R5)
    wr(1, 2, 32'h0000_0000, "R4");
    rd(0, 3, "R4");
    // R5 peer clear acknowledges
    wr(1, 2, 32'h0000_0004, "R5");
    rd(0, 3, "R5");
    rd(1, 2, "R6");
    // set and clear together: own set, peer clear
    wr(1, 2, 32'h0015_0000, "R4");
    wr(0, 2, 32'h002A_0015, "R5");
    rd(0, 3, "R5"); rd(1, 3, "R5");
    rd(0, 2, "R6");
    // R8 hold across idle cycles
    idle("R8"); idle("R8");
    // sweep masks channel by channel on both CPUs
    wr(0, 0, 32'h3, "R9"); wr(1, 0, 32'h3, "R9");
    for (int k = 0; k < NCH; k++) begin
      logic [31:0] m = 32'h003F_003F & ~((32'h1 << k) | (32'h1_0000 << k));
      wr(0, 1, m, "R9");
      wr(1, 1, m, "R10");
      rd(k % 2, 1, "R3");
    end
    wr(0, 0, 32'h0, "R9");
    wr(1, 0, 32'h2, "R10");
    wr(1, 2, 32'h003F_003F, "R5");
    wr(0, 2, 32'h0000_003F, "R5");
    rd(1, 3, "R7");
    idle("R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule